// File: doc/BRIEF.md
# Audio Zero-Run Detection Monitor

This block watches eight channels of 24-bit DAC sample data, one sample per channel on each frame strobe. Each channel has a run counter that counts consecutive all-zero frames. A channel is declared silent once its run reaches the configured length, which is 8192 frames by default. A routing stage folds the per-channel silence bits into two output flags. The channel groups behind each flag come from a mode table.

A detect-enable input picks the fixed default routing; otherwise a 4-bit mode value does. A parallel-control input holds both flags low over every other condition. When a soft-run bit is cleared, or the DAC power-enable input is low, both flags are forced high and the run counters restart from zero. Samples arrive already decoded; the serial audio port and the register interface sit outside.

Top module: `zdet_monitor`

## Requirements
- R1: A channel is silent only once 8192 consecutive frame strobes have each carried an all-zero sample on it; with default routing, flag1 is low after 8191 such strobes on all channels and high after the 8192nd.
- R2: A strobe carrying a nonzero sample on a channel restarts that channel's run, and any flag whose group contains that channel is low after that same strobe.
- R3: The run count saturates at 8192, so a flag stays high while zero frames keep arriving.
- R4: Run counters change only on a frame strobe; nonzero sample data without a strobe leaves the flags unchanged.
- R5: While soft_run is 0 or dac_pwr_n is 0 (and ctrl_parallel is 0), both flags are 1 and all run counters are cleared, so detection starts over when both return to 1.
- R6: While ctrl_parallel is 1, both flags are 0, regardless of every other input and the counter state.
- R7: With det_en = 1, the default routing applies and zmode is ignored: flag1 is the AND of channels 0-5 silent, and flag2 is the AND of channels 6-7 silent.
- R8: With det_en = 0, zmode selects the groups (bit n = channel n, each flag is the AND of its group): 0 -> 0x3F/0xC0, 1 -> 0x03/0x0C, 2 -> 0x30/0xC0, 3 -> 0x0F/0xF0, 4 -> 0x01/0x02, 5 -> 0x55/0xAA, 6 -> 0xFF/0xFF.
- R9: With det_en = 0 and zmode 7 or higher, both flags are 0.
- R10: Synchronous reset clears every run counter, so flags are 0 under default routing right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe marking a new frame of samples |
| samples | input | 192 | Channel n sample in bits [24n+23:24n] |
| ctrl_parallel | input | 1 | 1 = parallel control mode, flags held low |
| det_en | input | 1 | 1 = default routing, 0 = routing from zmode |
| zmode | input | 4 | Routing mode selector |
| soft_run | input | 1 | 0 = soft reset, flags forced high |
| dac_pwr_n | input | 1 | 0 = DAC powered down, flags forced high |
| zflag1 | output | 1 | First zero-detect flag |
| zflag2 | output | 1 | Second zero-detect flag |

## Verification
All channels first run silent across the 8191/8192 boundary and well past it. A one-frame nonzero sample is then put on a different single channel under each routing mode. This shows whether the flag that drops is the one whose group holds that channel, so a wrong mask or a swapped flag shows up. Vectors with every channel silent pair detect-enable with out-of-range mode values, which shows whether the default routing and the disabled modes win. Directed sequences layer parallel mode, soft reset and power-down on each other to test their priority and the counter restart.

// File: rtl/zdet_pkg.sv
package zdet_pkg;
    localparam int NCH = 8;

    typedef logic [NCH-1:0] ch_mask_t;

    typedef struct packed {
        ch_mask_t grp1;
        ch_mask_t grp2;
    } route_t;

    typedef enum logic [1:0] {
        SRC_DETECT  = 2'd0,
        SRC_FORCEHI = 2'd1,
        SRC_FORCELO = 2'd2
    } flag_src_e;

    // Group masks per routing mode; empty masks disable the flag.
    function automatic route_t route_for(input logic [3:0] sel);
        route_t r;
        case (sel)
            4'd0:    r = '{grp1: 8'h3F, grp2: 8'hC0};
            4'd1:    r = '{grp1: 8'h03, grp2: 8'h0C};
            4'd2:    r = '{grp1: 8'h30, grp2: 8'hC0};
            4'd3:    r = '{grp1: 8'h0F, grp2: 8'hF0};
            4'd4:    r = '{grp1: 8'h01, grp2: 8'h02};
            4'd5:    r = '{grp1: 8'h55, grp2: 8'hAA};
            4'd6:    r = '{grp1: 8'hFF, grp2: 8'hFF};
            default: r = '{grp1: 8'h00, grp2: 8'h00};
        endcase
        return r;
    endfunction

    function automatic logic group_silent(input ch_mask_t det, input ch_mask_t m);
        return (m != '0) && ((det & m) == m);
    endfunction
endpackage

// File: rtl/zdet_run_counter.sv
module zdet_run_counter #(
    parameter int DW      = 24,
    parameter int RUN_LEN = 8192
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          stb,
    input  logic [DW-1:0] sample,
    output logic          silent
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (stb) begin
            if (sample != '0)
                cnt <= '0;
            else if (cnt != LIMIT)
                cnt <= cnt + 1'b1;
        end
    end

    assign silent = (cnt == LIMIT);

    assert_reset_clears_R10: assert property (@(posedge clk) rst |=> cnt == '0);
    assert_saturate_R3: assert property (@(posedge clk) disable iff (rst) cnt <= LIMIT);
    assert_only_on_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        (!stb && !clr) |=> $stable(cnt));
    assert_nonzero_restarts_R2: assert property (@(posedge clk) disable iff (rst)
        (stb && sample != '0) |=> cnt == '0);
    assert_clr_restarts_R5: assert property (@(posedge clk) disable iff (rst)
        clr |=> !silent);
endmodule

// File: rtl/zdet_route.sv
module zdet_route
    import zdet_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ch_mask_t   silent,
    input  logic       ctrl_parallel,
    input  logic       det_en,
    input  logic [3:0] zmode,
    input  logic       soft_run,
    input  logic       dac_pwr_n,
    output logic       zflag1,
    output logic       zflag2
);
    flag_src_e  src;
    logic [3:0] eff_mode;
    route_t     rt;

    always_comb begin
        if (ctrl_parallel)
            src = SRC_FORCELO;
        else if (!soft_run || !dac_pwr_n)
            src = SRC_FORCEHI;
        else
            src = SRC_DETECT;
    end

    assign eff_mode = det_en ? 4'd0 : zmode;
    assign rt       = route_for(eff_mode);

    always_comb begin
        case (src)
            SRC_FORCELO: begin zflag1 = 1'b0; zflag2 = 1'b0; end
            SRC_FORCEHI: begin zflag1 = 1'b1; zflag2 = 1'b1; end
            default: begin
                zflag1 = group_silent(silent, rt.grp1);
                zflag2 = group_silent(silent, rt.grp2);
            end
        endcase
    end

    assert_parallel_low_R6: assert property (@(posedge clk) disable iff (rst)
        ctrl_parallel |-> (!zflag1 && !zflag2));
    assert_forced_high_R5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_parallel && (!soft_run || !dac_pwr_n)) |-> (zflag1 && zflag2));
    assert_modes_off_R9: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_parallel && soft_run && dac_pwr_n && !det_en && zmode >= 4'd7)
        |-> (!zflag1 && !zflag2));
    assert_default_group_R7: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_parallel && soft_run && dac_pwr_n && det_en && silent[7:6] != 2'b11)
        |-> !zflag2);
endmodule

// File: rtl/zdet_monitor.sv
module zdet_monitor
    import zdet_pkg::*;
#(
    parameter int DW      = 24,
    parameter int RUN_LEN = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic [NCH*DW-1:0] samples,
    input  logic              ctrl_parallel,
    input  logic              det_en,
    input  logic [3:0]        zmode,
    input  logic              soft_run,
    input  logic              dac_pwr_n,
    output logic              zflag1,
    output logic              zflag2
);
    ch_mask_t silent;
    logic     run_clr;

    assign run_clr = !soft_run || !dac_pwr_n;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        zdet_run_counter #(.DW(DW), .RUN_LEN(RUN_LEN)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .clr    (run_clr),
            .stb    (frame_stb),
            .sample (samples[ch*DW +: DW]),
            .silent (silent[ch])
        );
    end

    zdet_route u_route (
        .clk           (clk),
        .rst           (rst),
        .silent        (silent),
        .ctrl_parallel (ctrl_parallel),
        .det_en        (det_en),
        .zmode         (zmode),
        .soft_run      (soft_run),
        .dac_pwr_n     (dac_pwr_n),
        .zflag1        (zflag1),
        .zflag2        (zflag2)
    );

    assert_strobe_needed_R1: assert property (@(posedge clk) disable iff (rst)
        (!frame_stb && !run_clr) |=> $stable(silent));
endmodule

// File: tb/tb_zdet_monitor.sv
module tb_zdet_monitor;
    localparam int DW  = 24;
    localparam int NCH = 8;
    localparam int RUN = 8192;

    logic              clk = 1'b0;
    logic              rst;
    logic              frame_stb;
    logic [NCH*DW-1:0] samples;
    logic              ctrl_parallel, det_en, soft_run, dac_pwr_n;
    logic [3:0]        zmode;
    logic              zflag1, zflag2;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    zdet_monitor #(.DW(DW), .RUN_LEN(RUN)) dut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .samples(samples),
        .ctrl_parallel(ctrl_parallel), .det_en(det_en), .zmode(zmode),
        .soft_run(soft_run), .dac_pwr_n(dac_pwr_n),
        .zflag1(zflag1), .zflag2(zflag2)
    );

    typedef struct packed {
        logic [3:0] mode;
        logic       en;
        logic [3:0] nz;   // channel given one nonzero frame, 8 = none
        logic       e1;
        logic       e2;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  1'b1, 4'd8, 1'b1, 1'b1},  // R7 all silent
        '{4'd9,  1'b1, 4'd8, 1'b1, 1'b1},  // R7 register ignored
        '{4'd1,  1'b0, 4'd8, 1'b1, 1'b1},  // R8
        '{4'd7,  1'b0, 4'd8, 1'b0, 1'b0},  // R9
        '{4'd15, 1'b0, 4'd8, 1'b0, 1'b0},  // R9
        '{4'd0,  1'b0, 4'd6, 1'b1, 1'b0},  // R8 R2
        '{4'd0,  1'b0, 4'd2, 1'b0, 1'b1},  // R8 R2
        '{4'd1,  1'b0, 4'd2, 1'b1, 1'b0},  // R8
        '{4'd2,  1'b0, 4'd0, 1'b1, 1'b1},  // R8 channel outside groups
        '{4'd5,  1'b0, 4'd3, 1'b1, 1'b0},  // R8
        '{4'd4,  1'b0, 4'd1, 1'b1, 1'b0},  // R8
        '{4'd3,  1'b0, 4'd7, 1'b1, 1'b0},  // R8
        '{4'd6,  1'b0, 4'd5, 1'b0, 1'b0},  // R8
        '{4'd1,  1'b1, 4'd7, 1'b1, 1'b0}   // R7 default routing wins
    };

    task automatic check(input string tag, input logic e1, input logic e2);
        checks++;
        if (zflag1 !== e1 || zflag2 !== e2) begin
            errors++;
            $display("FAIL %s flags=%b%b expected %b%b", tag, zflag1, zflag2, e1, e2);
        end
    endtask

    task automatic run_zero(input int n);
        samples   = '0;
        frame_stb = 1'b1;
        repeat (n) @(negedge clk);
        frame_stb = 1'b0;
    endtask

    initial begin
        #(20 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; frame_stb = 1'b0; samples = '0;
        ctrl_parallel = 1'b0; det_en = 1'b1; zmode = 4'd0;
        soft_run = 1'b1; dac_pwr_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset state", 1'b0, 1'b0);

        run_zero(RUN - 1);
        check("R1 one frame short", 1'b0, 1'b0);
        run_zero(1);
        check("R1 run complete", 1'b1, 1'b1);
        run_zero(100);
        check("R3 saturated run", 1'b1, 1'b1);

        samples = {NCH{24'h00_0001}};
        repeat (3) @(negedge clk);
        samples = '0;
        check("R4 no strobe no change", 1'b1, 1'b1);

        for (int i = 0; i < NV; i++) begin
            det_en = VECS[i].en;
            zmode  = VECS[i].mode;
            if (VECS[i].nz != 4'd8) begin
                samples[VECS[i].nz*DW +: DW] = 24'h80_0123;
                frame_stb = 1'b1;
                @(negedge clk);
                frame_stb = 1'b0;
                samples = '0;
            end else begin
                @(negedge clk);
            end
            check($sformatf("R2/R7/R8/R9 vector %0d", i), VECS[i].e1, VECS[i].e2);
            if (VECS[i].nz != 4'd8) run_zero(RUN);
        end

        det_en = 1'b1; zmode = 4'd0;
        @(negedge clk);
        check("R7 restored", 1'b1, 1'b1);

        ctrl_parallel = 1'b1;
        @(negedge clk);
        check("R6 parallel with silence", 1'b0, 1'b0);
        soft_run = 1'b0;
        @(negedge clk);
        check("R6 parallel over soft reset", 1'b0, 1'b0);
        ctrl_parallel = 1'b0;
        @(negedge clk);
        check("R5 soft reset forces high", 1'b1, 1'b1);
        soft_run = 1'b1;
        @(negedge clk);
        check("R5 counters restarted", 1'b0, 1'b0);
        run_zero(RUN);
        check("R1 detect after restart", 1'b1, 1'b1);
        dac_pwr_n = 1'b0;
        @(negedge clk);
        check("R5 power-down forces high", 1'b1, 1'b1);
        dac_pwr_n = 1'b1;
        @(negedge clk);
        check("R5 power-down restarted counters", 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule